// File: doc/BRIEF.md
# Parallel Product-Term Expander Chain

This block builds the OR sums for groups of eight macrocells. Each cell has five product terms of its own. Through a per-cell pair of configuration bits, a cell can hand its terms upward to the next higher-numbered cell. That cell accepts them and ORs them with its own terms. It may in turn pass the combined set further up. A cell whose terms travel upward outputs 0. The cell at the top of a run outputs the OR of every term in the run, together with a count of the borrowed sets, which feeds timing annotation.

Runs never cross a group boundary. At most three sets may be borrowed. Every inconsistent configuration raises the fault flag of its group and forces the outputs of the affected run to 0. All outputs are registered one cycle after the inputs, and a synchronous active-high reset clears them.

Top module: `pxc_array`

## Requirements
- R1: A cell with its give bit `lend_i[c]` and take bit `borrow_i[c]` both 0 outputs `sum_o[c]` equal to the OR of its own terms `pt_i[c*5 +: 5]`, with `depth_o[c*2 +: 2]` = 0.
- R2: A cell in a valid run that gives its terms upward (`lend_i[c]`=1) outputs `sum_o[c]`=0 and depth 0, whatever its terms are.
- R3: A link exists between cells c-1 and c when `lend_i[c-1]` and `borrow_i[c]` are both 1. The top cell of a valid run outputs the OR of its own terms and the terms of every linked cell below it. Its depth equals the number of those linked cells.
- R4: A run of more than three borrowed sets is illegal. Its group's fault bit rises, and every cell of the run outputs sum 0 and depth 0.
- R5: Setting the take bit of the lowest cell of a group (cell index c where c mod 8 = 0) is illegal. It raises that group's fault bit and zeroes that cell.
- R6: Setting the give bit of the highest cell of a group (c mod 8 = 7) is illegal. It raises that group's fault bit and zeroes that cell.
- R7: A take bit whose lower neighbour does not give, or a give bit whose upper neighbour does not take, is illegal. It raises the group's fault bit and zeroes the cells of that run.
- R8: Groups are independent. Cells 0–7 form group 0 and cells 8–15 form group 1. A give on cell 7 never reaches cell 8, and a fault in one group leaves the other group's outputs and `err_o` bit unchanged.
- R9: A fault is confined to its own run. Other cells of the same group keep their normal sums and depths.
- R10: Outputs change one clock after the inputs. While reset is high, all outputs read 0 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pt_i | input | GROUPS*CELLS*TERMS | Product terms, five per cell, cell c at bits c*TERMS upward |
| lend_i | input | GROUPS*CELLS | Per-cell give bit: pass terms to the next higher cell |
| borrow_i | input | GROUPS*CELLS | Per-cell take bit: accept terms from the next lower cell |
| sum_o | output | GROUPS*CELLS | Registered OR sum per cell |
| depth_o | output | GROUPS*CELLS*2 | Registered count of borrowed sets per cell |
| err_o | output | GROUPS | Registered per-group configuration fault |

## Verification
A corrupted running accumulation or depth count inside a group shows at the ports exactly one clock after the inputs are applied. It appears as a wrong sum or depth on the top cell of a run, or as a lender that does not read 0. A wrong fault decision shows in the same cycle: either an `err_o` bit disagrees with the configuration, or a healthy cell in another run or group is wrongly zeroed. The tests therefore pair every faulting run with an independent healthy cell, and check both on the first sample after the edge.

// File: rtl/pxc_pkg.sv
package pxc_pkg;
  localparam int unsigned PX_MAX_SETS = 3;
  localparam int unsigned PX_DEPTH_W  = $clog2(PX_MAX_SETS + 1);
  localparam int unsigned PX_CELLS    = 8;
  localparam int unsigned PX_TERMS    = 5;
endpackage

// File: rtl/pxc_cell_or.sv
module pxc_cell_or #(
  parameter int unsigned TERMS = pxc_pkg::PX_TERMS
) (
  input  logic [TERMS-1:0] terms,
  output logic             hit
);
  assign hit = |terms;
endmodule

// File: rtl/pxc_group.sv
module pxc_group
  import pxc_pkg::*;
#(
  parameter int unsigned CELLS = PX_CELLS,
  parameter int unsigned TERMS = PX_TERMS
) (
  input  logic [CELLS*TERMS-1:0]      pt,
  input  logic [CELLS-1:0]            lend,
  input  logic [CELLS-1:0]            borrow,
  output logic [CELLS-1:0]            sum,
  output logic [CELLS*PX_DEPTH_W-1:0] depth,
  output logic                        fault
);
  localparam int unsigned CW = $clog2(CELLS) + 1;
  localparam logic [CW-1:0] MAXC = CW'(PX_MAX_SETS);

  logic [CELLS-1:0] own_hit;
  logic [CELLS-1:0] lend_below, borrow_above, link, link_above;
  logic [CELLS-1:0] in_ok, out_ok, flt, bad_up, bad;
  logic [CELLS-1:0] acc;
  logic [PX_DEPTH_W-1:0] dep [CELLS];

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    pxc_cell_or #(.TERMS(TERMS)) u_or (
      .terms(pt[i*TERMS +: TERMS]),
      .hit  (own_hit[i])
    );
  end

  assign lend_below   = {lend[CELLS-2:0], 1'b0};
  assign borrow_above = {1'b0, borrow[CELLS-1:1]};
  assign link         = lend_below & borrow;
  assign link_above   = {1'b0, link[CELLS-1:1]};
  assign in_ok        = ~borrow | lend_below;
  assign out_ok       = ~lend | borrow_above;

  always_comb begin
    logic [CW-1:0] run_d;
    logic          run_s;
    logic          run_b;
    run_d = '0;
    run_s = 1'b0;
    run_b = 1'b0;
    for (int i = 0; i < CELLS; i++) begin
      run_d     = link[i] ? run_d + 1'b1 : '0;
      run_s     = own_hit[i] | (link[i] & run_s);
      flt[i]    = ~in_ok[i] | ~out_ok[i] | (run_d > MAXC);
      run_b     = flt[i] | (link[i] & run_b);
      acc[i]    = run_s;
      dep[i]    = run_d[PX_DEPTH_W-1:0];
      bad_up[i] = run_b;
    end
  end

  always_comb begin
    logic run_b2;
    run_b2 = 1'b0;
    for (int i = CELLS - 1; i >= 0; i--) begin
      run_b2 = bad_up[i] | (link_above[i] & run_b2);
      bad[i] = run_b2;
    end
  end

  always_comb begin
    for (int i = 0; i < CELLS; i++) begin
      sum[i] = acc[i] & ~lend[i] & ~bad[i];
      depth[i*PX_DEPTH_W +: PX_DEPTH_W] = (lend[i] | bad[i]) ? '0 : dep[i];
    end
  end

  assign fault = |flt;
endmodule

// File: rtl/pxc_array.sv
module pxc_array
  import pxc_pkg::*;
#(
  parameter int unsigned GROUPS = 2,
  parameter int unsigned CELLS  = PX_CELLS,
  parameter int unsigned TERMS  = PX_TERMS
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [GROUPS*CELLS*TERMS-1:0]      pt_i,
  input  logic [GROUPS*CELLS-1:0]            lend_i,
  input  logic [GROUPS*CELLS-1:0]            borrow_i,
  output logic [GROUPS*CELLS-1:0]            sum_o,
  output logic [GROUPS*CELLS*PX_DEPTH_W-1:0] depth_o,
  output logic [GROUPS-1:0]                  err_o
);
  localparam int unsigned GPT = CELLS * TERMS;
  localparam int unsigned GDW = CELLS * PX_DEPTH_W;

  logic [GROUPS*CELLS-1:0]  sum_d;
  logic [GROUPS*GDW-1:0]    depth_d;
  logic [GROUPS-1:0]        err_d;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    pxc_group #(.CELLS(CELLS), .TERMS(TERMS)) u_grp (
      .pt    (pt_i[g*GPT +: GPT]),
      .lend  (lend_i[g*CELLS +: CELLS]),
      .borrow(borrow_i[g*CELLS +: CELLS]),
      .sum   (sum_d[g*CELLS +: CELLS]),
      .depth (depth_d[g*GDW +: GDW]),
      .fault (err_d[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o   <= '0;
      depth_o <= '0;
      err_o   <= '0;
    end else begin
      sum_o   <= sum_d;
      depth_o <= depth_d;
      err_o   <= err_d;
    end
  end
endmodule

// File: rtl/pxc_array_chk.sv
module pxc_array_chk
  import pxc_pkg::*;
#(
  parameter int unsigned GROUPS = 2,
  parameter int unsigned CELLS  = PX_CELLS,
  parameter int unsigned TERMS  = PX_TERMS
) (
  input logic                               clk,
  input logic                               rst,
  input logic [GROUPS*CELLS*TERMS-1:0]      pt_i,
  input logic [GROUPS*CELLS-1:0]            lend_i,
  input logic [GROUPS*CELLS-1:0]            borrow_i,
  input logic [GROUPS*CELLS-1:0]            sum_o,
  input logic [GROUPS*CELLS*PX_DEPTH_W-1:0] depth_o,
  input logic [GROUPS-1:0]                  err_o
);
  localparam int unsigned NC = GROUPS * CELLS;

  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (sum_o == '0 && depth_o == '0 && err_o == '0));

  for (genvar c = 0; c < NC; c++) begin : g_c
    p_solo_sum_r1: assert property (@(posedge clk) disable iff (rst)
      (!lend_i[c] && !borrow_i[c]) |=>
        (sum_o[c] == $past(|pt_i[c*TERMS +: TERMS]) &&
         depth_o[c*PX_DEPTH_W +: PX_DEPTH_W] == '0));

    p_lend_quiet_r2: assert property (@(posedge clk) disable iff (rst)
      lend_i[c] |=> (!sum_o[c] && depth_o[c*PX_DEPTH_W +: PX_DEPTH_W] == '0));

    if (c % CELLS == 0) begin : g_first
      p_first_take_r5: assert property (@(posedge clk) disable iff (rst)
        borrow_i[c] |=> err_o[c / CELLS]);
    end else begin : g_inner
      p_depth_src_r3: assert property (@(posedge clk) disable iff (rst)
        !(lend_i[c-1] && borrow_i[c]) |=>
          depth_o[c*PX_DEPTH_W +: PX_DEPTH_W] == '0);
    end

    if (c % CELLS == CELLS - 1) begin : g_last
      p_last_give_r6: assert property (@(posedge clk) disable iff (rst)
        lend_i[c] |=> err_o[c / CELLS]);
    end
  end
endmodule

bind pxc_array pxc_array_chk #(.GROUPS(GROUPS), .CELLS(CELLS), .TERMS(TERMS)) u_chk (
  .clk(clk), .rst(rst), .pt_i(pt_i), .lend_i(lend_i), .borrow_i(borrow_i),
  .sum_o(sum_o), .depth_o(depth_o), .err_o(err_o)
);

// File: tb/pxc_array_tb.sv
module pxc_array_tb_top;
  localparam int G = 2;
  localparam int N = 8;
  localparam int T = 5;
  localparam int NC = G * N;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NC*T-1:0] pt = '0;
  logic [NC-1:0]   lend = '0;
  logic [NC-1:0]   borrow = '0;
  logic [NC-1:0]   sum_o;
  logic [NC*2-1:0] depth_o;
  logic [G-1:0]    err_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pxc_array #(.GROUPS(G), .CELLS(N), .TERMS(T)) dut_i (
    .clk(clk), .rst(rst), .pt_i(pt), .lend_i(lend), .borrow_i(borrow),
    .sum_o(sum_o), .depth_o(depth_o), .err_o(err_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cs(input string req, input int c, input int s, input int d);
    chk(req, $sformatf("sum[%0d]", c), int'(sum_o[c]), s);
    chk(req, $sformatf("depth[%0d]", c), int'(depth_o[c*2 +: 2]), d);
  endtask

  task automatic ce(input string req, input int e0, input int e1);
    chk(req, "err[0]", int'(err_o[0]), e0);
    chk(req, "err[1]", int'(err_o[1]), e1);
  endtask

  task automatic clear_cfg();
    pt = '0; lend = '0; borrow = '0;
  endtask

  task automatic apply();
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R10", "reset sum", int'(|sum_o), 0);
    chk("R10", "reset depth", int'(|depth_o), 0);
    chk("R10", "reset err", int'(|err_o), 0);
  endtask

  task automatic t_solo();
    @(negedge clk); clear_cfg();
    pt[3*T +: T] = 5'b10000; pt[9*T +: T] = 5'b00001;
    apply();
    cs("R1", 0, 0, 0); cs("R1", 3, 1, 0); cs("R1", 9, 1, 0); cs("R1", 12, 0, 0);
    ce("R1", 0, 0);
  endtask

  task automatic t_latency();
    @(negedge clk); clear_cfg();
    pt[3*T +: T] = 5'b00000;
    #2 chk("R10", "sum[3] before edge", int'(sum_o[3]), 1);
    @(negedge clk);
    chk("R10", "sum[3] after edge", int'(sum_o[3]), 0);
  endtask

  task automatic t_pair();
    @(negedge clk); clear_cfg();
    lend[4] = 1'b1; borrow[5] = 1'b1; pt[4*T +: T] = 5'b00100;
    apply();
    cs("R2", 4, 0, 0); cs("R3", 5, 1, 1); ce("R3", 0, 0);
    @(negedge clk); pt[4*T +: T] = 5'b0;
    apply();
    cs("R3", 5, 0, 1);
  endtask

  task automatic t_three();
    @(negedge clk); clear_cfg();
    lend[3:1] = 3'b111; borrow[4:2] = 3'b111;
    pt[1*T +: T] = 5'b00010; pt[0*T +: T] = 5'b00001;
    apply();
    cs("R3", 4, 1, 3); cs("R2", 1, 0, 0); cs("R2", 2, 0, 0); cs("R2", 3, 0, 0);
    cs("R1", 0, 1, 0); ce("R3", 0, 0);
  endtask

  task automatic t_four();
    @(negedge clk); clear_cfg();
    lend[3:0] = 4'hF; borrow[4:1] = 4'hF;
    pt[4*T +: T] = 5'b00001; pt[0*T +: T] = 5'b11111; pt[6*T +: T] = 5'b01000;
    apply();
    cs("R4", 4, 0, 0); ce("R4", 1, 0); cs("R9", 6, 1, 0);
  endtask

  task automatic t_first();
    @(negedge clk); clear_cfg();
    borrow[8] = 1'b1; pt[8*T +: T] = 5'b00001; pt[2*T +: T] = 5'b00001;
    apply();
    cs("R5", 8, 0, 0); ce("R5", 0, 1); cs("R8", 2, 1, 0);
  endtask

  task automatic t_last();
    @(negedge clk); clear_cfg();
    lend[7] = 1'b1; pt[7*T +: T] = 5'b00001; pt[5*T +: T] = 5'b10000;
    apply();
    cs("R6", 7, 0, 0); ce("R6", 1, 0); cs("R9", 5, 1, 0);
  endtask

  task automatic t_cross();
    @(negedge clk); clear_cfg();
    lend[7] = 1'b1; borrow[8] = 1'b1; pt[7*T +: T] = 5'b00001;
    apply();
    cs("R8", 8, 0, 0); cs("R8", 7, 0, 0); ce("R8", 1, 1);
  endtask

  task automatic t_mismatch();
    @(negedge clk); clear_cfg();
    borrow[13] = 1'b1; pt[12*T +: T] = 5'b00001; pt[13*T +: T] = 5'b00001;
    apply();
    cs("R7", 13, 0, 0); cs("R7", 12, 1, 0); ce("R7", 0, 1);
    @(negedge clk); clear_cfg();
    lend[10] = 1'b1; pt[10*T +: T] = 5'b00001; pt[11*T +: T] = 5'b00100;
    apply();
    cs("R7", 10, 0, 0); cs("R7", 11, 1, 0); ce("R7", 0, 1);
  endtask

  task automatic t_confine();
    @(negedge clk); clear_cfg();
    lend[9] = 1'b1; borrow[10] = 1'b1; pt[9*T +: T] = 5'b00001;
    borrow[14] = 1'b1; pt[14*T +: T] = 5'b00001;
    apply();
    cs("R9", 10, 1, 1); cs("R9", 14, 0, 0); ce("R9", 0, 1);
  endtask

  task automatic t_reset_mid();
    @(negedge clk); clear_cfg();
    lend[3:1] = 3'b111; borrow[4:2] = 3'b111; pt[1*T +: T] = 5'b00010;
    apply();
    cs("R3", 4, 1, 3);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R10", "sum after reset", int'(|sum_o), 0);
    chk("R10", "depth after reset", int'(|depth_o), 0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    rst = 1'b0;
    t_solo();
    t_latency();
    t_pair();
    t_three();
    t_four();
    t_first();
    t_last();
    t_cross();
    t_mismatch();
    t_confine();
    t_reset_mid();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule